// File: doc/BRIEF.md
# Shared Inter-Thread FIFO Cell

This block is a single queue cell that several hardware threads use to pass data to one another. Each access names a view, a direction (read or write), the thread that issues it and, for writes, a data word. The view decides how the access behaves:

- **Blocking view:** asks the thread to come back later when the queue cannot serve it.
- **Non-blocking view:** always completes, even when it cannot move data.
- **Peek/poke view:** reaches the end entries without moving them.
- **Tag view:** reads or changes the cell's status word.

Answers arrive one cycle after the request. Each answer is either a completion or a retry.

The cell records in a bitmap every thread that was told to retry. When a later access removes the condition that stopped those threads, the cell clears the bitmap and pulses a wake output that carries the bitmap, so those threads can reissue their accesses. Queue depth, data width and thread count are parameters. The defaults are 4 entries of 32 bits and 8 threads.

Top module: `xthread_fifo_cell`

## Requirements
- R1: `req_view` is encoded as 0 = blocking, 1 = non-blocking, 2 = peek/poke and 3 = tag. In the blocking and non-blocking views, a write to a non-full cell appends the data and completes. A read from a non-empty cell removes the oldest entry and returns it. Entries leave in arrival order, including when the storage pointers wrap.
- R2: The Empty flag is 1 exactly when the cell holds no entries. The Full flag is 1 exactly when it holds DEPTH entries. Both flags follow every append, removal and flush.
- R3: In the blocking view, a read from an empty cell or a write to a full cell answers with retry and not with done. It leaves the queue and flags unchanged, and it records the requesting thread in the waiting bitmap.
- R4: The non-blocking view never answers retry. A write to a full cell completes and its data is dropped. A read from an empty cell completes with data 0.
- R5: A peek/poke read completes with the oldest entry and does not remove it. It returns 0 when the cell is empty. Peek/poke accesses never change Empty or Full.
- R6: A peek/poke write replaces the newest entry and leaves the entry count unchanged. On an empty cell it has no effect.
- R7: A tag-view read completes with the status word: bit 0 is Empty, bit 1 is Full, bit 2 is the type bit and reads 1 (FIFO cell), and all other bits are 0. The tag view never answers retry.
- R8: A tag-view write with bit 0 set empties the queue in that cycle, so Empty becomes 1 and Full becomes 0. Writes to bits 1, 2 and above are ignored. A tag-view write with bit 0 clear leaves the queue unchanged.
- R9: Every request gets exactly one of `rsp_done` or `rsp_retry`, one cycle after the request. Neither output is raised without a request. `rsp_rdata` is 0 unless a read completes.
- R10: Three events release the waiting threads: an append to an empty cell, a removal from a full cell, and a flush of a full cell. If the waiting bitmap is non-zero at such an event, `wake_valid` pulses one cycle later with `wake_mask` equal to the bitmap, and the bitmap is cleared. `wake_mask` is 0 when `wake_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_view | input | 2 | View: 0 blocking, 1 non-blocking, 2 peek/poke, 3 tag |
| req_write | input | 1 | 1 = write, 0 = read |
| req_tid | input | TID_W (3) | Issuing thread number |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_done | output | 1 | The access completed |
| rsp_retry | output | 1 | The access stalled; the thread must reissue it |
| rsp_rdata | output | DATA_W (32) | Read result |
| wake_valid | output | 1 | Waiting threads are released |
| wake_mask | output | THREADS (8) | Bitmap of the released threads |

## Verification
The blocking view is driven into both edges of the cell: reads on an empty cell and writes on a full one. This separates retry handling from completion, and it shows that the waiting bitmap gathers several threads before a single wake releases them together. The same edges are then hit through the non-blocking view, which separates dropping or zero-returning from stalling. Peek and poke are interleaved with normal traffic to confirm that they neither move entries nor flip flags. A long append/remove run wraps the storage pointers several times to expose ordering errors. Flushes are issued both with waiters present and with the flush bit clear, which separates a real flush from an ignored tag write.

// File: rtl/xfc_pkg.sv
package xfc_pkg;

    typedef enum logic [1:0] {
        VIEW_SYNC   = 2'd0,
        VIEW_TRY    = 2'd1,
        VIEW_BYPASS = 2'd2,
        VIEW_CTRL   = 2'd3
    } view_e;

    localparam int TAG_EMPTY_BIT = 0;
    localparam int TAG_FULL_BIT  = 1;
    localparam int TAG_TYPE_BIT  = 2;

endpackage

// File: rtl/xfc_queue.sv
module xfc_queue #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic              replace_newest,
    input  logic              flush,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic              empty,
    output logic              full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             rd;
        logic [PTR_W-1:0]             wr;
        logic [CNT_W-1:0]             cnt;
    } q_t;

    q_t q_q, q_d;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic [PTR_W-1:0] newest_idx;

    always_comb begin
        newest_idx = (q_q.wr == '0) ? PTR_W'(DEPTH - 1) : q_q.wr - PTR_W'(1);
        q_d = q_q;
        if (flush) begin
            q_d.rd  = '0;
            q_d.wr  = '0;
            q_d.cnt = '0;
        end else if (push) begin
            q_d.mem[q_q.wr] = wdata;
            q_d.wr          = step(q_q.wr);
            q_d.cnt         = q_q.cnt + CNT_W'(1);
        end else if (pop) begin
            q_d.rd  = step(q_q.rd);
            q_d.cnt = q_q.cnt - CNT_W'(1);
        end else if (replace_newest && (q_q.cnt != '0)) begin
            q_d.mem[newest_idx] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head  = q_q.mem[q_q.rd];
    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CNT_W'(DEPTH));

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(empty && full));
    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full));

endmodule

// File: rtl/xfc_waitmap.sv
module xfc_waitmap #(
    parameter int THREADS = 8,
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               park,
    input  logic [TID_W-1:0]   park_tid,
    input  logic               release_all,
    output logic               wake_valid,
    output logic [THREADS-1:0] wake_mask
);
    typedef struct packed {
        logic [THREADS-1:0] waiting;
        logic               wake_v;
        logic [THREADS-1:0] wake_m;
    } w_t;

    w_t w_q, w_d;

    always_comb begin
        w_d         = w_q;
        w_d.wake_v  = 1'b0;
        w_d.wake_m  = '0;
        if (park) begin
            w_d.waiting[park_tid] = 1'b1;
        end else if (release_all && (w_q.waiting != '0)) begin
            w_d.wake_v  = 1'b1;
            w_d.wake_m  = w_q.waiting;
            w_d.waiting = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign wake_valid = w_q.wake_v;
    assign wake_mask  = w_q.wake_m;

    assert_wake_nonempty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |-> (wake_mask != '0));
    assert_wake_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wake_valid |=> !wake_valid);
    assert_mask_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wake_valid |-> (wake_mask == '0));

endmodule

// File: rtl/xthread_fifo_cell.sv
module xthread_fifo_cell #(
    parameter int DATA_W  = 32,
    parameter int DEPTH   = 4,
    parameter int THREADS = 8,
    parameter int TID_W   = (THREADS > 1) ? $clog2(THREADS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_view,
    input  logic               req_write,
    input  logic [TID_W-1:0]   req_tid,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               rsp_done,
    output logic               rsp_retry,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               wake_valid,
    output logic [THREADS-1:0] wake_mask
);
    import xfc_pkg::*;

    typedef struct packed {
        logic              done;
        logic              retry;
        logic [DATA_W-1:0] rdata;
    } rsp_t;

    rsp_t r_q, r_d;

    view_e             view;
    logic              q_push, q_pop, q_replace, q_flush;
    logic              q_empty, q_full;
    logic [DATA_W-1:0] q_head;
    logic              w_park, w_release;

    assign view = view_e'(req_view);

    always_comb begin
        r_d       = '0;
        q_push    = 1'b0;
        q_pop     = 1'b0;
        q_replace = 1'b0;
        q_flush   = 1'b0;
        w_park    = 1'b0;
        w_release = 1'b0;
        if (req_valid) begin
            case (view)
                VIEW_SYNC, VIEW_TRY: begin
                    if (req_write) begin
                        if (q_full) begin
                            if (view == VIEW_SYNC) begin
                                r_d.retry = 1'b1;
                                w_park    = 1'b1;
                            end else begin
                                r_d.done  = 1'b1;
                            end
                        end else begin
                            r_d.done  = 1'b1;
                            q_push    = 1'b1;
                            w_release = q_empty;
                        end
                    end else begin
                        if (q_empty) begin
                            if (view == VIEW_SYNC) begin
                                r_d.retry = 1'b1;
                                w_park    = 1'b1;
                            end else begin
                                r_d.done  = 1'b1;
                            end
                        end else begin
                            r_d.done  = 1'b1;
                            r_d.rdata = q_head;
                            q_pop     = 1'b1;
                            w_release = q_full;
                        end
                    end
                end
                VIEW_BYPASS: begin
                    r_d.done = 1'b1;
                    if (req_write) q_replace = 1'b1;
                    else if (!q_empty) r_d.rdata = q_head;
                end
                VIEW_CTRL: begin
                    r_d.done = 1'b1;
                    if (req_write) begin
                        if (req_wdata[TAG_EMPTY_BIT]) begin
                            q_flush   = 1'b1;
                            w_release = q_full;
                        end
                    end else begin
                        r_d.rdata[TAG_EMPTY_BIT] = q_empty;
                        r_d.rdata[TAG_FULL_BIT]  = q_full;
                        r_d.rdata[TAG_TYPE_BIT]  = 1'b1;
                    end
                end
                default: r_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    xfc_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
        .clk            (clk),
        .rst_n          (rst_n),
        .push           (q_push),
        .pop            (q_pop),
        .replace_newest (q_replace),
        .flush          (q_flush),
        .wdata          (req_wdata),
        .head           (q_head),
        .empty          (q_empty),
        .full           (q_full)
    );

    xfc_waitmap #(.THREADS(THREADS), .TID_W(TID_W)) u_waitmap (
        .clk         (clk),
        .rst_n       (rst_n),
        .park        (w_park),
        .park_tid    (req_tid),
        .release_all (w_release),
        .wake_valid  (wake_valid),
        .wake_mask   (wake_mask)
    );

    assign rsp_done  = r_q.done;
    assign rsp_retry = r_q.retry;
    assign rsp_rdata = r_q.rdata;

    assert_single_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_done && rsp_retry));
    assert_answer_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_done || rsp_retry));
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_done && !rsp_retry));
    assert_retry_keeps_flags_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_retry |-> (q_empty == $past(q_empty) && q_full == $past(q_full)));
    assert_bypass_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && view == VIEW_BYPASS) |=> ($stable(q_empty) && $stable(q_full)));
    assert_tag_never_stalls_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && view == VIEW_CTRL) |=> rsp_done);

endmodule

// File: tb/xthread_fifo_cell_bench.sv
module xthread_fifo_cell_bench;
    localparam int DATA_W  = 32;
    localparam int DEPTH   = 4;
    localparam int THREADS = 8;
    localparam int TID_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_valid = 1'b0;
    logic [1:0]         req_view = '0;
    logic               req_write = 1'b0;
    logic [TID_W-1:0]   req_tid = '0;
    logic [DATA_W-1:0]  req_wdata = '0;
    logic               rsp_done, rsp_retry, wake_valid;
    logic [DATA_W-1:0]  rsp_rdata;
    logic [THREADS-1:0] wake_mask;

    int vectors = 0;
    int miscompares = 0;

    // reference model state
    logic [DATA_W-1:0]  mq[$];
    logic [THREADS-1:0] mwait = '0;

    always #10 clk = ~clk;

    xthread_fifo_cell u_xthread_fifo_cell (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_view(req_view),
        .req_write(req_write), .req_tid(req_tid), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata),
        .wake_valid(wake_valid), .wake_mask(wake_mask)
    );

    task automatic compare(input string tag, input logic e_done, input logic e_retry,
                           input logic [DATA_W-1:0] e_rdata, input logic e_wake,
                           input logic [THREADS-1:0] e_mask);
        bit bad = 0;
        vectors++;
        if (rsp_done !== e_done) begin
            $display("FAIL %s rsp_done actual %b expected %b", tag, rsp_done, e_done); bad = 1;
        end
        if (rsp_retry !== e_retry) begin
            $display("FAIL %s rsp_retry actual %b expected %b", tag, rsp_retry, e_retry); bad = 1;
        end
        if (rsp_rdata !== e_rdata) begin
            $display("FAIL %s rsp_rdata actual %h expected %h", tag, rsp_rdata, e_rdata); bad = 1;
        end
        if (wake_valid !== e_wake) begin
            $display("FAIL %s wake_valid actual %b expected %b", tag, wake_valid, e_wake); bad = 1;
        end
        if (wake_mask !== e_mask) begin
            $display("FAIL %s wake_mask actual %h expected %h", tag, wake_mask, e_mask); bad = 1;
        end
        if (bad) miscompares++;
    endtask

    task automatic access(input logic [1:0] v, input bit wr, input int tid,
                          input logic [DATA_W-1:0] wd, input string tag);
        logic e_done = 0, e_retry = 0, e_wake = 0, rel = 0;
        logic [DATA_W-1:0]  e_rdata = '0;
        logic [THREADS-1:0] e_mask = '0;
        int n = mq.size();
        case (v)
            2'd0, 2'd1: begin
                if (wr) begin
                    if (n == DEPTH) begin
                        if (v == 2'd0) begin e_retry = 1; mwait[tid] = 1'b1; end
                        else e_done = 1;
                    end else begin
                        e_done = 1; mq.push_back(wd); rel = (n == 0);
                    end
                end else begin
                    if (n == 0) begin
                        if (v == 2'd0) begin e_retry = 1; mwait[tid] = 1'b1; end
                        else e_done = 1;
                    end else begin
                        e_done = 1; e_rdata = mq.pop_front(); rel = (n == DEPTH);
                    end
                end
            end
            2'd2: begin
                e_done = 1;
                if (wr) begin
                    if (n != 0) mq[n-1] = wd;
                end else if (n != 0) e_rdata = mq[0];
            end
            default: begin
                e_done = 1;
                if (wr) begin
                    if (wd[0]) begin rel = (n == DEPTH); mq.delete(); end
                end else begin
                    e_rdata = {29'd0, 1'b1, (n == DEPTH), (n == 0)};
                end
            end
        endcase
        if (rel && mwait != '0) begin
            e_wake = 1; e_mask = mwait; mwait = '0;
        end
        @(negedge clk);
        req_valid = 1'b1; req_view = v; req_write = wr;
        req_tid = TID_W'(tid); req_wdata = wd;
        @(posedge clk); #2;
        compare(tag, e_done, e_retry, e_rdata, e_wake, e_mask);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0; req_wdata = '0;
        @(posedge clk); #2;
        compare(tag, 1'b0, 1'b0, '0, 1'b0, '0);
    endtask

    initial begin
        #4_000_000;
        miscompares++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle("R9 reset state");
        access(2'd3, 0, 0, 0, "R7 tag after reset");
        access(2'd1, 0, 1, 0, "R4 try read empty");
        access(2'd2, 0, 1, 0, "R5 bypass read empty");
        access(2'd2, 1, 1, 32'hDEAD, "R6 bypass write empty");
        access(2'd3, 0, 0, 0, "R6 still empty");
        access(2'd0, 0, 3, 0, "R3 sync read empty t3");
        access(2'd0, 0, 5, 0, "R3 sync read empty t5");
        access(2'd0, 1, 0, 32'hA1, "R10 push wakes readers");
        access(2'd0, 1, 0, 32'hA2, "R1 push");
        access(2'd1, 1, 0, 32'hA3, "R1 try push");
        access(2'd0, 1, 0, 32'hA4, "R1 push to full");
        access(2'd3, 0, 0, 0, "R2 tag full");
        access(2'd0, 1, 1, 32'hE1, "R3 sync write full t1");
        access(2'd1, 1, 2, 32'hE2, "R4 try write full dropped");
        access(2'd0, 1, 6, 32'hE3, "R3 sync write full t6");
        access(2'd2, 0, 0, 0, "R5 bypass peek");
        access(2'd2, 1, 0, 32'hB4, "R6 bypass replace newest");
        access(2'd3, 0, 0, 0, "R5 flags unchanged");
        access(2'd0, 0, 0, 0, "R10 pop wakes writers");
        access(2'd1, 0, 0, 0, "R1 order");
        access(2'd0, 0, 0, 0, "R1 order");
        access(2'd1, 0, 0, 0, "R6 replaced value");
        access(2'd3, 0, 0, 0, "R2 tag empty again");
        access(2'd1, 1, 0, 32'hC1, "R1 push");
        access(2'd1, 1, 0, 32'hC2, "R1 push");
        access(2'd3, 1, 0, 32'hFFFF_FFFE, "R8 tag write bit0 clear");
        access(2'd3, 0, 0, 0, "R8 tag partial");
        access(2'd1, 0, 0, 0, "R8 data kept");
        access(2'd1, 1, 0, 32'hC3, "R1 push");
        access(2'd1, 1, 0, 32'hC4, "R1 push");
        access(2'd1, 1, 0, 32'hC5, "R1 push to full");
        access(2'd0, 1, 7, 32'hE7, "R3 sync write full t7");
        access(2'd3, 1, 0, 32'h1, "R8 flush wakes R10");
        access(2'd3, 0, 0, 0, "R8 tag after flush");
        access(2'd1, 0, 0, 0, "R8 read after flush");
        for (int k = 0; k < 12; k++) begin
            access(2'd1, 1, k % THREADS, 32'h100 + k, "R1 wrap push");
            access(2'd0, 1, k % THREADS, 32'h200 + k, "R1 wrap push");
            access(2'd0, 0, k % THREADS, 0, "R1 wrap pop");
            access(2'd1, 0, k % THREADS, 0, "R1 wrap pop");
        end
        idle("R9 idle at end");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule